// File: doc/BRIEF.md
# Fixed-Disk Adapter Status and Attention Registers

This block is the register front end of a simple fixed-disk adapter as the host sees it on an 8-bit I/O bus. Two 16-bit port addresses are decoded. The first port reads back the adapter status and takes writes to the control register. The second port reads back the interrupt status and takes writes to the attention register.

The registers have side effects, and these are what the block models. A control write with its top bit set raises one status flag. A nonzero attention value reloads the whole status byte with a fixed pattern. Reading interrupt status acknowledges the pending interrupt. A completion pulse from the adapter core raises that pending flag. While the flag is set it drives the `irq` line.

The control and attention values leave the block as outputs for the adapter core. The command protocol, the data path and the drive itself sit outside this block.

Top module: `dskadp_top`

## Requirements
- R1: After a synchronous active-high reset, status, control, attention and interrupt status are all 0x00, and `irq` is low.
- R2: `io_rdata` is combinational on the current address. Address 0x322 gives the status byte, 0x324 gives the interrupt-status byte, and any other address gives 0xFF.
- R3: A write to 0x322 stores the data byte as the control register. It appears on `ctl_out` after the clock edge.
- R4: A control write with data bit 7 set sets status bit 1 (mask 0x02) and leaves the other status bits as they were. A control write with bit 7 clear leaves status unchanged.
- R5: A write to 0x324 stores data bits 7:4 as the attention value with bits 3:0 forced to zero. The value appears on `attn_out` after the edge.
- R6: When the stored attention value is nonzero, status becomes 0x14. When it is zero (data upper nibble 0), status is unchanged.
- R7: A read strobe at 0x324 returns the interrupt-status byte in that cycle. Bit 1 of interrupt status is cleared at the clock edge that ends the read.
- R8: A high `done_in` sets interrupt-status bit 1 at the next edge. `irq` equals interrupt-status bit 1, and the other interrupt-status bits stay zero.
- R9: If `done_in` and a clearing read of 0x324 fall in the same cycle, bit 1 ends up set.
- R10: All 16 address bits are decoded. Reads or writes at any other address change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 16 | I/O port address |
| io_wr | input | 1 | Write strobe, one cycle per access |
| io_rd | input | 1 | Read strobe, one cycle per access |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the current address |
| done_in | input | 1 | Completion pulse from the adapter core |
| ctl_out | output | 8 | Stored control register |
| attn_out | output | 8 | Stored attention value, low nibble zero |
| irq | output | 1 | Interrupt request, interrupt-status bit 1 |

## Verification
The bench first writes an attention byte whose only set bits are in the low nibble. A design that tested the raw byte instead of the masked value would wrongly reload status to 0x14.

It sets control bit 7 on top of an already loaded status. This shows the bit is ORed in, not loaded, so a design that overwrote status would lose 0x14.

It pulses completion in the same cycle as the acknowledging read. A design where the clear takes priority would drop the interrupt.

It also hits the neighbouring address 0x323 and an unmapped read. A partial decode would then corrupt registers or return the wrong byte.

// File: rtl/dskadp_pkg.sv
package dskadp_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 16;

    localparam logic [ADDR_W-1:0] PORT_STAT = 16'h0322;
    localparam logic [ADDR_W-1:0] PORT_INTR = 16'h0324;

    localparam logic [DATA_W-1:0] RD_IDLE      = 8'hFF;
    localparam logic [DATA_W-1:0] STAT_ON_ATTN = 8'h14;
    localparam int                CTL_KICK_BIT = 7;
    localparam int                STAT_KICK_BIT = 1;
    localparam int                INT_PEND_BIT = 1;
    localparam logic [DATA_W-1:0] ATTN_KEEP    = 8'hF0;

    typedef struct packed {
        logic sel_stat;
        logic sel_intr;
        logic wr_stat;
        logic wr_attn;
        logic rd_intr;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] attn_mask(input logic [DATA_W-1:0] d);
        return d & ATTN_KEEP;
    endfunction

endpackage

// File: rtl/dskadp_decode.sv
module dskadp_decode
    import dskadp_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output bus_req_t          req
);
    always_comb begin
        req.sel_stat = (addr == PORT_STAT);
        req.sel_intr = (addr == PORT_INTR);
        req.wr_stat  = req.sel_stat & wr;
        req.wr_attn  = req.sel_intr & wr;
        req.rd_intr  = req.sel_intr & rd;
    end
endmodule

// File: rtl/dskadp_stat.sv
module dskadp_stat
    import dskadp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl_q,
    output logic [DATA_W-1:0] stat_q
);
    localparam logic [DATA_W-1:0] KICK_MASK = DATA_W'(1) << STAT_KICK_BIT;

    logic load_attn;
    assign load_attn = req.wr_attn && (attn_mask(wdata) != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            stat_q <= '0;
        end else begin
            if (req.wr_stat) begin
                ctl_q <= wdata;
                if (wdata[CTL_KICK_BIT])
                    stat_q <= stat_q | KICK_MASK;
            end
            if (load_attn)
                stat_q <= STAT_ON_ATTN;
        end
    end

    // R4: kick sets bit 1 and preserves the rest
    a_r4_kick_sets: assert property (@(posedge clk) disable iff (rst)
        (req.wr_stat && wdata[CTL_KICK_BIT]) |=> stat_q[STAT_KICK_BIT]);
    a_r4_others_kept: assert property (@(posedge clk) disable iff (rst)
        req.wr_stat |=> ((stat_q | KICK_MASK) == ($past(stat_q) | KICK_MASK)));
    // R6: nonzero attention loads the fixed pattern
    a_r6_attn_load: assert property (@(posedge clk) disable iff (rst)
        (req.wr_attn && wdata[7:4] != 4'h0) |=> (stat_q == STAT_ON_ATTN));
    // R10: no status change without a write to either port
    a_r10_stat_hold: assert property (@(posedge clk) disable iff (rst)
        (!req.wr_stat && !req.wr_attn) |=> $stable(stat_q));
endmodule

// File: rtl/dskadp_intr.sv
module dskadp_intr
    import dskadp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] wdata,
    input  logic              done,
    output logic [DATA_W-1:0] attn_q,
    output logic [DATA_W-1:0] int_q
);
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            attn_q <= '0;
            pend_q <= 1'b0;
        end else begin
            if (req.wr_attn)
                attn_q <= attn_mask(wdata);
            if (done)
                pend_q <= 1'b1;
            else if (req.rd_intr)
                pend_q <= 1'b0;
        end
    end

    always_comb begin
        int_q = '0;
        int_q[INT_PEND_BIT] = pend_q;
    end

    // R9: completion wins over the acknowledging read
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        done |=> int_q[INT_PEND_BIT]);
    // R7: read without completion clears the flag
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (req.rd_intr && !done) |=> !int_q[INT_PEND_BIT]);
    // R5: low nibble of attention is never set
    a_r5_low_zero: assert property (@(posedge clk) disable iff (rst)
        req.wr_attn |=> (attn_q[3:0] == 4'h0));
endmodule

// File: rtl/dskadp_top.sv
module dskadp_top
    import dskadp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              done_in,
    output logic [DATA_W-1:0] ctl_out,
    output logic [DATA_W-1:0] attn_out,
    output logic              irq
);
    bus_req_t          req;
    logic [DATA_W-1:0] stat_q;
    logic [DATA_W-1:0] int_q;

    dskadp_decode u_dec (
        .addr (io_addr),
        .wr   (io_wr),
        .rd   (io_rd),
        .req  (req)
    );

    dskadp_stat u_stat (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .wdata  (io_wdata),
        .ctl_q  (ctl_out),
        .stat_q (stat_q)
    );

    dskadp_intr u_intr (
        .clk    (clk),
        .rst    (rst),
        .req    (req),
        .wdata  (io_wdata),
        .done   (done_in),
        .attn_q (attn_out),
        .int_q  (int_q)
    );

    always_comb begin
        if (req.sel_stat)
            io_rdata = stat_q;
        else if (req.sel_intr)
            io_rdata = int_q;
        else
            io_rdata = RD_IDLE;
    end

    assign irq = int_q[INT_PEND_BIT];

    // R8: irq rises the edge after a completion pulse
    a_r8_irq_rise: assert property (@(posedge clk) disable iff (rst)
        done_in |=> irq);
    // R1: everything clear the cycle after reset
    a_r1_reset: assert property (@(posedge clk)
        rst |=> (ctl_out == '0 && attn_out == '0 && !irq));
endmodule

// File: tb/sim_dskadp_top.sv
module sim_dskadp_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] io_addr = '0;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        done_in = 1'b0;
    logic [7:0]  ctl_out;
    logic [7:0]  attn_out;
    logic        irq;

    int errors = 0;
    int checks = 0;

    // behavioural reference state
    logic [7:0] m_stat = '0, m_ctl = '0, m_attn = '0, m_int = '0;

    always #5 clk = ~clk;

    dskadp_top u0 (
        .clk(clk), .rst(rst), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .done_in(done_in),
        .ctl_out(ctl_out), .attn_out(attn_out), .irq(irq)
    );

    task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input logic [15:0] a);
        if (a == 16'h0322) return m_stat;
        if (a == 16'h0324) return m_int;
        return 8'hFF;
    endfunction

    task automatic step(input string tag, input logic [15:0] a, input logic w, input logic r,
                        input logic [7:0] d, input logic dn);
        @(negedge clk);
        io_addr = a; io_wr = w; io_rd = r; io_wdata = d; done_in = dn;
        #1;
        chk(tag, "rdata", io_rdata, exp_rd(a));
        @(posedge clk);
        if (w && a == 16'h0322) begin
            m_ctl = d;
            if (d[7]) m_stat = m_stat | 8'h02;
        end
        if (w && a == 16'h0324) begin
            m_attn = d & 8'hF0;
            if (m_attn != 8'h00) m_stat = 8'h14;
        end
        if (r && a == 16'h0324) m_int = m_int & ~8'h02;
        if (dn) m_int = m_int | 8'h02;
        #2;
        io_wr = 1'b0; io_rd = 1'b0; done_in = 1'b0;
        chk(tag, "ctl_out", ctl_out, m_ctl);
        chk(tag, "attn_out", attn_out, m_attn);
        chk(tag, "irq", {7'b0, irq}, {7'b0, m_int[1]});
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        chk("R1", "ctl reset", ctl_out, 8'h00);
        chk("R1", "attn reset", attn_out, 8'h00);
        chk("R1", "irq reset", {7'b0, irq}, 8'h00);
        step("R1", 16'h0322, 0, 1, 8'h00, 0);
        step("R1", 16'h0324, 0, 1, 8'h00, 0);
        step("R2", 16'h0100, 0, 1, 8'h00, 0);
        step("R3", 16'h0322, 1, 0, 8'h05, 0);
        step("R4", 16'h0322, 0, 1, 8'h00, 0);
        step("R4", 16'h0322, 1, 0, 8'h85, 0);
        step("R4", 16'h0322, 0, 1, 8'h00, 0);
        step("R5", 16'h0324, 1, 0, 8'h0F, 0);
        step("R6", 16'h0322, 0, 1, 8'h00, 0);
        step("R5", 16'h0324, 1, 0, 8'hA7, 0);
        step("R6", 16'h0322, 0, 1, 8'h00, 0);
        step("R4", 16'h0322, 1, 0, 8'h80, 0);
        step("R4", 16'h0322, 0, 1, 8'h00, 0);
        step("R10", 16'h0323, 1, 0, 8'hFF, 0);
        step("R10", 16'h0325, 1, 1, 8'hF0, 0);
        step("R10", 16'h0322, 0, 1, 8'h00, 0);
        step("R8", 16'h0000, 0, 0, 8'h00, 1);
        step("R8", 16'h0326, 0, 1, 8'h00, 0);
        step("R7", 16'h0324, 0, 1, 8'h00, 0);
        step("R7", 16'h0324, 0, 1, 8'h00, 0);
        step("R9", 16'h0324, 0, 1, 8'h00, 1);
        step("R9", 16'h0324, 0, 0, 8'h00, 0);
        step("R7", 16'h0324, 0, 1, 8'h00, 0);
        step("R6", 16'h0324, 1, 0, 8'h30, 0);
        step("R6", 16'h0322, 0, 1, 8'h00, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule